// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block owns the status byte of a serial flash memory. It also decides whether each state-changing request may run: a status write, a page program, or a sector, block or chip erase. Each request arrives as a decoded single-cycle strobe, with the target address and the level of the active-low hardware write-protect pin. The block answers one cycle later with a grant or a reject pulse. A granted request raises the write-in-progress bit, which holds until the array sequencer pulses `busy_done_i`.

Protection has three layers:
- The write enable latch must be set before any write request is granted.
- A two-bit protect level selects which part of the array is locked.
- A hardware mode freezes the protection bits. It applies while the status-write-disable bit is set and the pin is held low.

If more than one strobe is raised in a cycle, only one is taken, in this priority order: chip erase, block erase, sector erase, page program, status write, write disable, write enable.

Top module: `sr_guard`

## Requirements
- R1: The status byte reads bit7 = write disable, bits 6..4 = 0, bit3/bit2 = protect level bits 1/0, bit1 = write enable latch, bit0 = write-in-progress. After reset it is 0x0C (default protect level 11, everything else 0).
- R2: While idle, a write-enable strobe sets bit1 and a write-disable strobe clears it.
- R3: A status write, program or erase with bit1 = 0 is rejected and leaves the status byte unchanged.
- R4: While bit7 = 1 and `wp_ni` = 0, a status write is rejected and bits 7, 3 and 2 stay unchanged. With `wp_ni` = 1 the same write is granted.
- R5: A granted status write copies data bit7 into bit7 and data bits 3..2 into bits 3..2. It ignores the other data bits and sets bit0 at the same edge.
- R6: `addr_prot_o` combinationally flags `addr_i` as locked. Level 00 locks nothing. Level 01 locks block `LOCK_BLOCK` (default: addr bit16 = 1). Levels 10 and 11 lock everything. When the parameter `FULL_MAP` = 0, any nonzero level locks everything.
- R7: A program, sector erase or block erase aimed at a locked address is rejected and bit1 stays set. When aimed at an unlocked address, it is granted and bit0 is set.
- R8: A chip erase is granted only when the protect level is 00.
- R9: Each request yields exactly one single-cycle pulse on either `grant_o` or `reject_o`, in the cycle after its strobe.
- R10: `busy_done_i` while bit0 = 1 clears bit0 and bit1 at the same edge. While bit0 = 0 it has no effect.
- R11: While bit0 = 1, every request is rejected, and write-enable and write-disable strobes have no effect. This includes the cycle in which `busy_done_i` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_ni | input | 1 | Hardware write-protect pin level, active low |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write request |
| wrsr_data_i | input | 8 | Byte offered by the status write |
| pp_i | input | 1 | Page-program request |
| se_i | input | 1 | Sector-erase request |
| be_i | input | 1 | Block-erase request |
| ce_i | input | 1 | Chip-erase request |
| addr_i | input | ADDR_W | Target address of the request |
| busy_done_i | input | 1 | End of self-timed cycle pulse |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Request accepted pulse |
| reject_o | output | 1 | Request refused pulse |
| addr_prot_o | output | 1 | `addr_i` lies in the locked region |

## Verification
Two functions can land in the same cycle: the end-of-cycle pulse, and a new request or latch strobe. The bench provokes this by raising `busy_done_i` together with a sector-erase strobe while a program is in flight. The request must see the device as still busy, so it must be rejected. One edge later, both the write-in-progress bit and the latch must read 0. Status writes made while the protect pin changes level are judged the same way, on the grant or reject pulse and on the byte that follows.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_WRSR, OP_PP, OP_SE, OP_BE, OP_CE
  } op_e;

  typedef struct packed {
    logic       srwd;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } sr_t;

  function automatic logic [7:0] sr_byte(input sr_t s);
    return {s.srwd, 3'b000, s.bp, s.wel, s.wip};
  endfunction

  function automatic logic is_write_req(input op_e op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_BE) || (op == OP_CE);
  endfunction

endpackage

// File: rtl/sr_region_check.sv
module sr_region_check #(
  parameter int IDX_W      = 1,
  parameter int LOCK_BLOCK = 1,
  parameter bit FULL_MAP   = 1'b1
) (
  input  logic [1:0]       bp_i,
  input  logic [IDX_W-1:0] blk_i,
  output logic             prot_o
);

  generate
    if (FULL_MAP) begin : g_full
      always_comb begin
        unique case (bp_i)
          2'b00:   prot_o = 1'b0;
          2'b01:   prot_o = (blk_i == IDX_W'(LOCK_BLOCK));
          default: prot_o = 1'b1;
        endcase
      end
    end else begin : g_coarse
      logic unused_blk;
      assign unused_blk = ^blk_i;
      assign prot_o     = |bp_i;
    end
  endgenerate

endmodule

// File: rtl/sr_status_reg.sv
module sr_status_reg
  import sr_guard_pkg::*;
#(
  parameter logic [1:0] BP_RST = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_wel_i,
  input  logic       clr_wel_i,
  input  logic       load_i,
  input  logic [7:0] load_data_i,
  input  logic       start_i,
  input  logic       done_i,
  output sr_t        sr_o
);

  sr_t sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q.srwd <= 1'b0;
      sr_q.bp   <= BP_RST;
      sr_q.wel  <= 1'b0;
      sr_q.wip  <= 1'b0;
    end else begin
      if (load_i) begin
        sr_q.srwd <= load_data_i[7];
        sr_q.bp   <= load_data_i[3:2];
      end
      if (done_i)       sr_q.wip <= 1'b0;
      else if (start_i) sr_q.wip <= 1'b1;
      if (set_wel_i)      sr_q.wel <= 1'b1;
      else if (clr_wel_i) sr_q.wel <= 1'b0;
    end
  end

  assign sr_o = sr_q;

  // R10: end of cycle drops busy and latch together
  p_done_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q.wip && done_i) |=> (!sr_q.wip && !sr_q.wel));

  // R10: busy holds until the done pulse
  p_wip_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_q.wip && !done_i) |=> sr_q.wip);

endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int         ADDR_W     = 17,
  parameter int         BLOCK_W    = 16,
  parameter int         LOCK_BLOCK = (1 << (ADDR_W - BLOCK_W)) - 1,
  parameter bit         FULL_MAP   = 1'b1,
  parameter logic [1:0] BP_RST     = 2'b11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic              pp_i,
  input  logic              se_i,
  input  logic              be_i,
  input  logic              ce_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_done_i,
  output logic [7:0]        status_o,
  output logic              grant_o,
  output logic              reject_o,
  output logic              addr_prot_o
);

  localparam int IDX_W = ADDR_W - BLOCK_W;

  sr_t  sr;
  op_e  op_d, op_q;
  logic busy, hw_lock, ok, accept, deny, done;
  logic grant_q, reject_q;

  logic unused_bits;
  assign unused_bits = ^{addr_i[BLOCK_W-1:0], wrsr_data_i[6:4], wrsr_data_i[1:0]};

  always_comb begin
    if (ce_i)        op_d = OP_CE;
    else if (be_i)   op_d = OP_BE;
    else if (se_i)   op_d = OP_SE;
    else if (pp_i)   op_d = OP_PP;
    else if (wrsr_i) op_d = OP_WRSR;
    else if (wrdi_i) op_d = OP_WRDI;
    else if (wren_i) op_d = OP_WREN;
    else             op_d = OP_NONE;
  end

  sr_region_check #(
    .IDX_W      (IDX_W),
    .LOCK_BLOCK (LOCK_BLOCK),
    .FULL_MAP   (FULL_MAP)
  ) u_region (
    .bp_i   (sr.bp),
    .blk_i  (addr_i[ADDR_W-1:BLOCK_W]),
    .prot_o (addr_prot_o)
  );

  assign busy    = sr.wip;
  assign hw_lock = sr.srwd & ~wp_ni;
  assign done    = busy & busy_done_i;

  always_comb begin
    unique case (op_d)
      OP_WRSR:            ok = sr.wel & ~hw_lock;
      OP_PP, OP_SE, OP_BE: ok = sr.wel & ~addr_prot_o;
      OP_CE:              ok = sr.wel & (sr.bp == 2'b00);
      default:            ok = 1'b0;
    endcase
  end

  assign accept = is_write_req(op_d) & ~busy & ok;
  assign deny   = is_write_req(op_d) & ~accept;

  sr_status_reg #(.BP_RST(BP_RST)) u_sr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_wel_i   ((op_d == OP_WREN) & ~busy),
    .clr_wel_i   (((op_d == OP_WRDI) & ~busy) | done),
    .load_i      (accept & (op_d == OP_WRSR)),
    .load_data_i (wrsr_data_i),
    .start_i     (accept),
    .done_i      (done),
    .sr_o        (sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q  <= 1'b0;
      reject_q <= 1'b0;
      op_q     <= OP_NONE;
    end else begin
      grant_q  <= accept;
      reject_q <= deny;
      op_q     <= op_d;
    end
  end

  assign grant_o  = grant_q;
  assign reject_o = reject_q;
  assign status_o = sr_byte(sr);

  p_grant_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> $past(sr.wel));

  p_hw_lock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr.srwd && !wp_ni) |=> ($stable(sr.bp) && sr.srwd));

  p_ce_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && op_q == OP_CE) |-> ($past(sr.bp) == 2'b00));

  p_one_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && reject_o));

  p_busy_reject_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr.wip && is_write_req(op_d)) |=> reject_o);

endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;

  localparam logic [3:0] NOP = 0, WREN = 1, WRDI = 2, WRSR = 3, PP = 4,
                         SE = 5, BE = 6, CE = 7, DONE = 8;

  // {op, req, wp_n, data, addr, exp_status, {exp_grant, exp_reject}}
  localparam int VW = 44;
  localparam int NV = 39;
  localparam logic [VW-1:0] VEC [NV] = '{
    {PP,   4'd3,  1'b1, 8'h00, 17'h00000, 8'h0C, 2'b01}, // R3 latch clear
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h0E, 2'b00}, // R2
    {WRSR, 4'd5,  1'b1, 8'h00, 17'h00000, 8'h03, 2'b10}, // R5
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h00, 2'b00}, // R10
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h02, 2'b00},
    {WRSR, 4'd5,  1'b1, 8'h84, 17'h00000, 8'h87, 2'b10},
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h84, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b00},
    {WRSR, 4'd4,  1'b0, 8'h00, 17'h00000, 8'h86, 2'b01}, // R4 locked
    {WRSR, 4'd4,  1'b1, 8'hF4, 17'h00000, 8'h87, 2'b10}, // R4 pin high, R5 masks
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h84, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b00},
    {PP,   4'd7,  1'b1, 8'h00, 17'h10000, 8'h86, 2'b01}, // R7 locked block
    {PP,   4'd7,  1'b1, 8'h00, 17'h0FFFF, 8'h87, 2'b10}, // R7 open block
    {WREN, 4'd11, 1'b1, 8'h00, 17'h00000, 8'h87, 2'b00}, // R11
    {SE,   4'd11, 1'b1, 8'h00, 17'h00000, 8'h87, 2'b01}, // R11
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h84, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b00},
    {CE,   4'd8,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b01}, // R8 level 01
    {BE,   4'd7,  1'b1, 8'h00, 17'h1FFFF, 8'h86, 2'b01},
    {BE,   4'd7,  1'b1, 8'h00, 17'h00000, 8'h87, 2'b10},
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h84, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b00},
    {WRDI, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h84, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h86, 2'b00},
    {WRSR, 4'd5,  1'b1, 8'h08, 17'h00000, 8'h0B, 2'b10},
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h08, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h0A, 2'b00},
    {SE,   4'd7,  1'b1, 8'h00, 17'h00100, 8'h0A, 2'b01}, // R7 level 10
    {WRSR, 4'd4,  1'b0, 8'h00, 17'h00000, 8'h03, 2'b10}, // R4 bit7 clear
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h00, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h02, 2'b00},
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h02, 2'b00}, // R10 idle
    {CE,   4'd8,  1'b1, 8'h00, 17'h00000, 8'h03, 2'b10}, // R8 level 00
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h00, 2'b00},
    {WREN, 4'd2,  1'b1, 8'h00, 17'h00000, 8'h02, 2'b00},
    {PP,   4'd9,  1'b1, 8'h00, 17'h00000, 8'h03, 2'b10}, // R9
    {WRDI, 4'd11, 1'b1, 8'h00, 17'h00000, 8'h03, 2'b00}, // R11
    {DONE, 4'd10, 1'b1, 8'h00, 17'h00000, 8'h00, 2'b00}
  };

  logic clk = 1'b0, rst_n = 1'b0, wp_n = 1'b1;
  logic wren = 0, wrdi = 0, wrsr = 0, pp = 0, se = 0, be = 0, ce = 0, bdone = 0;
  logic [7:0] wdata = 8'h00;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic grant, reject, aprot;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_guard u0 (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .wren_i(wren), .wrdi_i(wrdi),
    .wrsr_i(wrsr), .wrsr_data_i(wdata), .pp_i(pp), .se_i(se), .be_i(be),
    .ce_i(ce), .addr_i(addr), .busy_done_i(bdone), .status_o(status),
    .grant_o(grant), .reject_o(reject), .addr_prot_o(aprot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle; outputs sampled 1 time unit after the edge
  task automatic step(input logic [3:0] op, input logic w, input logic [7:0] d,
                      input logic [AW-1:0] a, input logic extra_done);
    @(negedge clk);
    wp_n = w; wdata = d; addr = a;
    wren = (op == WREN); wrdi = (op == WRDI); wrsr = (op == WRSR);
    pp = (op == PP); se = (op == SE); be = (op == BE); ce = (op == CE);
    bdone = (op == DONE) | extra_done;
    @(posedge clk); #1;
    {wren, wrdi, wrsr, pp, se, be, ce, bdone} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 reset status", 32'(status), 32'h0C);
    check("R9 reset pulses", 32'({grant, reject}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43:40], VEC[i][35], VEC[i][34:27], VEC[i][26:10], 1'b0);
      check($sformatf("R%0d vec %0d status", VEC[i][39:36], i), 32'(status), 32'(VEC[i][9:2]));
      check($sformatf("R%0d vec %0d result", VEC[i][39:36], i), 32'({grant, reject}), 32'(VEC[i][1:0]));
    end

    // R11 done pulse and new request in one cycle
    step(WREN, 1'b1, 8'h00, '0, 1'b0);
    step(PP, 1'b1, 8'h00, '0, 1'b0);
    check("R11 program started", 32'(status), 32'h03);
    step(SE, 1'b1, 8'h00, '0, 1'b1);
    check("R11 same-cycle request rejected", 32'({grant, reject}), 32'h1);
    check("R11 same-cycle done clears", 32'(status), 32'h00);
    step(NOP, 1'b1, 8'h00, '0, 1'b0);
    check("R9 pulse single cycle", 32'({grant, reject}), 32'h0);

    // R6 region map
    addr = 17'h1FFFF; #1;
    check("R6 level 00 open", 32'(aprot), 32'h0);
    step(WREN, 1'b1, 8'h00, '0, 1'b0);
    step(WRSR, 1'b1, 8'h04, '0, 1'b0);
    step(DONE, 1'b1, 8'h00, '0, 1'b0);
    addr = 17'h10000; #1;
    check("R6 level 01 upper block", 32'(aprot), 32'h1);
    addr = 17'h0FFFF; #1;
    check("R6 level 01 lower block", 32'(aprot), 32'h0);
    step(WREN, 1'b1, 8'h00, '0, 1'b0);
    step(WRSR, 1'b1, 8'h0C, '0, 1'b0);
    step(DONE, 1'b1, 8'h00, '0, 1'b0);
    addr = 17'h00000; #1;
    check("R6 level 11 all", 32'(aprot), 32'h1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule